// File: doc/BRIEF.md
# Register-file execute stage for a small 5-bit-opcode instruction set

This block executes one already-decoded instruction per strobe. An instruction is a 5-bit opcode and two operand bytes, A and B. The block holds four 8-bit registers (ax, bx, cx and dx) and three compare flags. On each strobe it updates the registers and flags, and it reports whether a jump was taken together with the jump's 8-bit target. A fetch or sequencing stage upstream presents the instruction fields and pulses `exec_i`. It reads `branch_o` and `target_o` one clock later to redirect its program counter.

The block handles these instructions:
- a literal load;
- four accumulator arithmetic operations on ax;
- an unsigned compare;
- an unconditional jump and seven conditional jumps;
- two bit-mask combines of ax, bx and dx;
- a clear of all state.

Any other 5-bit opcode does nothing. This includes the codes that a full machine would use for stack, call/return, data memory and reset. All results are registered, so every effect of an instruction becomes visible in the cycle after its strobe.

Top module: `exu_core`

## Requirements
- R1: After an asynchronous active-low reset, the outputs read as follows: all registers are zero, `flags_o` is zero, `branch_o` is low and `target_o` is zero.
- R2: While `exec_i` is low, no register, flag or target changes, and `branch_o` is low in the following cycle.
- R3: Opcode 0x10 writes the literal byte B into the register named by A. The register encoding is ax=0, bx=1, cx=2 and dx=3, and `regs_o[8n+7:8n]` shows register n. Flags are unchanged. A register operand of 4 or more reads as zero and is never written.
- R4: Opcodes 0x00 (add), 0x01 (sub) and 0x02 (mul) write ax op reg[A], modulo 256, into ax. They set the zero flag if the result is 0 and clear the greater and less flags.
- R5: Opcode 0x0F writes floor(ax / reg[A]) into ax and updates the flags as in R4. When reg[A] is zero it changes nothing.
- R6: Opcode 0x13 compares reg[A] with reg[B] as unsigned values. The flag layout is `flags_o[0]` for equal/zero, `flags_o[1]` for A greater than B and `flags_o[2]` for A less than B. Exactly one flag is set afterwards, and no flag combination other than one-hot or all-zero ever appears.
- R7: Opcode 0x05 always jumps. After the strobe, `branch_o` is high for exactly one cycle, and `target_o` takes the value that reg[A] held before the instruction.
- R8: The conditional jumps are taken on these conditions:
  - 0x08 when greater is set;
  - 0x09 when greater or zero is set;
  - 0x0A when less is set;
  - 0x0B when less or zero is set;
  - 0x0C and 0x0D when zero is set;
  - 0x0E when zero is clear.

  A taken conditional jump behaves as in R7. When the jump is not taken, `branch_o` stays low and `target_o` holds its value.
- R9: Opcode 0x1A writes (ax AND dx) OR bx into reg[A], and opcode 0x1B writes dx OR bx into reg[A]. Both read the operands' values from before the instruction and leave the flags unchanged.
- R10: Opcode 0x03 clears all four registers and all flags. `target_o` is unchanged.
- R11: Every opcode not listed in R3 to R10 changes no register, flag or target and leaves `branch_o` low. An instruction fires only when all five opcode bits match its code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| exec_i | input | 1 | Execute strobe, one instruction per high cycle |
| opcode_i | input | 5 | Instruction opcode |
| op_a_i | input | 8 | Operand A (register index) |
| op_b_i | input | 8 | Operand B (literal or register index) |
| regs_o | output | 32 | Register contents, register n at bits 8n+7:8n |
| flags_o | output | 3 | Flags: bit 0 zero/equal, bit 1 greater, bit 2 less |
| branch_o | output | 1 | Jump taken by the previous instruction |
| target_o | output | 8 | Target of the most recent taken jump |

## Verification
The assertions check the following on every cycle:
- an idle strobe changes no state and raises no branch;
- the flags are never more than one-hot;
- a clear empties the registers and flags;
- a literal load lands in the named register;
- an unconditional jump yields a pulse carrying the old value of the named register;
- an opcode outside the map leaves all state untouched.

Only the bench's scenarios can show the following:
- the arithmetic values, including wrap-around and results equal to zero;
- the skip on division by zero;
- the flag ordering of unsigned compares at the extremes;
- which conditional jumps are taken for each flag state;
- the mask results;
- the handling of out-of-range register operands.

// File: rtl/exu_pkg.sv
package exu_pkg;
  parameter int unsigned OPW = 5;

  typedef struct packed {
    logic lt;
    logic gt;
    logic zf;
  } flags_t;

  localparam logic [OPW-1:0] OP_ADD  = 5'h00;
  localparam logic [OPW-1:0] OP_SUB  = 5'h01;
  localparam logic [OPW-1:0] OP_MUL  = 5'h02;
  localparam logic [OPW-1:0] OP_CLR  = 5'h03;
  localparam logic [OPW-1:0] OP_JMP  = 5'h05;
  localparam logic [OPW-1:0] OP_JG   = 5'h08;
  localparam logic [OPW-1:0] OP_JGE  = 5'h09;
  localparam logic [OPW-1:0] OP_JL   = 5'h0A;
  localparam logic [OPW-1:0] OP_JLE  = 5'h0B;
  localparam logic [OPW-1:0] OP_JE   = 5'h0C;
  localparam logic [OPW-1:0] OP_JZ   = 5'h0D;
  localparam logic [OPW-1:0] OP_JNZ  = 5'h0E;
  localparam logic [OPW-1:0] OP_DIV  = 5'h0F;
  localparam logic [OPW-1:0] OP_MOVL = 5'h10;
  localparam logic [OPW-1:0] OP_CMP  = 5'h13;
  localparam logic [OPW-1:0] OP_MSK  = 5'h1A;
  localparam logic [OPW-1:0] OP_MSKB = 5'h1B;
endpackage

// File: rtl/exu_regfile.sv
module exu_regfile #(
  parameter int unsigned NREGS = 4,
  parameter int unsigned W     = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      clr_i,
  input  logic                      we_i,
  input  logic [W-1:0]              waddr_i,
  input  logic [W-1:0]              wdata_i,
  input  logic [W-1:0]              raddr_a_i,
  input  logic [W-1:0]              raddr_b_i,
  output logic [W-1:0]              rdata_a_o,
  output logic [W-1:0]              rdata_b_o,
  output logic [NREGS-1:0][W-1:0]   regs_o
);
  logic [NREGS-1:0][W-1:0] regs_q;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                regs_q[i] <= '0;
      else if (clr_i)                             regs_q[i] <= '0;
      else if (we_i && waddr_i == W'(i))          regs_q[i] <= wdata_i;
    end
  end

  // out-of-range index reads zero
  always_comb begin
    rdata_a_o = '0;
    rdata_b_o = '0;
    for (int i = 0; i < NREGS; i++) begin
      if (raddr_a_i == W'(i)) rdata_a_o = regs_q[i];
      if (raddr_b_i == W'(i)) rdata_b_o = regs_q[i];
    end
  end

  assign regs_o = regs_q;

  // R10
  clr_empties_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (regs_q == '0));
endmodule

// File: rtl/exu_alu.sv
module exu_alu
  import exu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OPW-1:0] opcode_i,
  input  logic [W-1:0]   op_a_i,
  input  logic [W-1:0]   op_b_i,
  input  logic [W-1:0]   ra_i,
  input  logic [W-1:0]   rb_i,
  input  logic [W-1:0]   ax_i,
  input  logic [W-1:0]   bx_i,
  input  logic [W-1:0]   dx_i,
  input  flags_t         flags_i,
  output logic           we_o,
  output logic [W-1:0]   waddr_o,
  output logic [W-1:0]   wdata_o,
  output logic           clr_o,
  output flags_t         flags_o
);
  logic [W-1:0] arith;
  logic         arith_we;

  always_comb begin
    arith    = ax_i;
    arith_we = 1'b0;
    case (opcode_i)
      OP_ADD: begin arith = ax_i + ra_i; arith_we = 1'b1; end
      OP_SUB: begin arith = ax_i - ra_i; arith_we = 1'b1; end
      OP_MUL: begin arith = ax_i * ra_i; arith_we = 1'b1; end
      OP_DIV: begin
        if (ra_i != '0) begin
          arith    = ax_i / ra_i;
          arith_we = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_comb begin
    we_o    = 1'b0;
    waddr_o = op_a_i;
    wdata_o = op_b_i;
    clr_o   = 1'b0;
    flags_o = flags_i;
    if (arith_we) begin
      we_o    = 1'b1;
      waddr_o = '0;
      wdata_o = arith;
      flags_o = '{lt: 1'b0, gt: 1'b0, zf: (arith == '0)};
    end else begin
      case (opcode_i)
        OP_MOVL: we_o = 1'b1;
        OP_MSK: begin
          we_o    = 1'b1;
          wdata_o = (ax_i & dx_i) | bx_i;
        end
        OP_MSKB: begin
          we_o    = 1'b1;
          wdata_o = dx_i | bx_i;
        end
        OP_CMP: flags_o = '{lt: (ra_i < rb_i), gt: (ra_i > rb_i), zf: (ra_i == rb_i)};
        OP_CLR: begin
          clr_o   = 1'b1;
          flags_o = '0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/exu_branch.sv
module exu_branch
  import exu_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [OPW-1:0] opcode_i,
  input  flags_t         flags_i,
  input  logic [W-1:0]   ra_i,
  output logic           take_o,
  output logic [W-1:0]   target_o
);
  always_comb begin
    case (opcode_i)
      OP_JMP:        take_o = 1'b1;
      OP_JG:         take_o = flags_i.gt;
      OP_JGE:        take_o = flags_i.gt | flags_i.zf;
      OP_JL:         take_o = flags_i.lt;
      OP_JLE:        take_o = flags_i.lt | flags_i.zf;
      OP_JE, OP_JZ:  take_o = flags_i.zf;
      OP_JNZ:        take_o = ~flags_i.zf;
      default:       take_o = 1'b0;
    endcase
  end

  assign target_o = ra_i;
endmodule

// File: rtl/exu_core.sv
module exu_core
  import exu_pkg::*;
#(
  parameter int unsigned NREGS = 4,
  parameter int unsigned W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 exec_i,
  input  logic [OPW-1:0]       opcode_i,
  input  logic [W-1:0]         op_a_i,
  input  logic [W-1:0]         op_b_i,
  output logic [NREGS*W-1:0]   regs_o,
  output logic [2:0]           flags_o,
  output logic                 branch_o,
  output logic [W-1:0]         target_o
);
  localparam int unsigned IDX_AX = 0;
  localparam int unsigned IDX_BX = 1;
  localparam int unsigned IDX_DX = 3;

  logic [NREGS-1:0][W-1:0] regs;
  logic [W-1:0]            ra, rb, waddr, wdata, tgt_d, target_q;
  logic                    we, clr, take, branch_q;
  flags_t                  flags_q, flags_d;

  exu_regfile #(.NREGS(NREGS), .W(W)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (exec_i & clr),
    .we_i      (exec_i & we),
    .waddr_i   (waddr),
    .wdata_i   (wdata),
    .raddr_a_i (op_a_i),
    .raddr_b_i (op_b_i),
    .rdata_a_o (ra),
    .rdata_b_o (rb),
    .regs_o    (regs)
  );

  exu_alu #(.W(W)) u_alu (
    .opcode_i (opcode_i),
    .op_a_i   (op_a_i),
    .op_b_i   (op_b_i),
    .ra_i     (ra),
    .rb_i     (rb),
    .ax_i     (regs[IDX_AX]),
    .bx_i     (regs[IDX_BX]),
    .dx_i     (regs[IDX_DX]),
    .flags_i  (flags_q),
    .we_o     (we),
    .waddr_o  (waddr),
    .wdata_o  (wdata),
    .clr_o    (clr),
    .flags_o  (flags_d)
  );

  exu_branch #(.W(W)) u_br (
    .opcode_i (opcode_i),
    .flags_i  (flags_q),
    .ra_i     (ra),
    .take_o   (take),
    .target_o (tgt_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q  <= '0;
      branch_q <= 1'b0;
      target_q <= '0;
    end else begin
      branch_q <= exec_i & take;
      if (exec_i) flags_q <= flags_d;
      if (exec_i && take) target_q <= tgt_d;
    end
  end

  assign regs_o   = regs;
  assign flags_o  = flags_q;
  assign branch_o = branch_q;
  assign target_o = target_q;

  // R2
  idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exec_i |=> ($stable(regs) && $stable(flags_q) && $stable(target_q) && !branch_q));

  // R6
  flags_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(flags_o));

  // R3
  movl_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i == OP_MOVL && op_a_i < W'(NREGS))
      |=> (regs[$past(op_a_i[1:0])] == $past(op_b_i)));

  // R7
  jmp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i == OP_JMP) |=> (branch_o && target_o == $past(ra)));

  // R10
  clr_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i == OP_CLR) |=> (flags_o == 3'b000 && regs_o == '0));

  // R11
  unlisted_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_i && opcode_i inside {5'h04, 5'h06, 5'h07, [5'h11:5'h12], [5'h14:5'h19], [5'h1C:5'h1F]})
      |=> ($stable(regs) && $stable(flags_q) && $stable(target_q) && !branch_o));
endmodule

// File: tb/tb_exu_core.sv
module tb_exu_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exec = 1'b0;
  logic [4:0]  opcode = '0;
  logic [7:0]  op_a = '0, op_b = '0;
  logic [31:0] regs;
  logic [2:0]  flags;
  logic        branch;
  logic [7:0]  target;

  int total = 0, fails = 0;
  bit done = 0;

  int m_r[4];
  int m_fl, m_tgt;
  bit m_br;

  always #10 clk = ~clk;

  exu_core dut (
    .clk_i(clk), .rst_ni(rst_n), .exec_i(exec), .opcode_i(opcode),
    .op_a_i(op_a), .op_b_i(op_b), .regs_o(regs), .flags_o(flags),
    .branch_o(branch), .target_o(target)
  );

  function automatic int rd(int idx);
    return (idx < 4) ? m_r[idx] : 0;
  endfunction

  function automatic string tag_of(int op);
    case (op)
      'h10: return "R3";
      'h00, 'h01, 'h02: return "R4";
      'h0F: return "R5";
      'h13: return "R6";
      'h05: return "R7";
      'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h0E: return "R8";
      'h1A, 'h1B: return "R9";
      'h03: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic model_step(int op, int a, int b);
    int ax, res, x, y;
    bit jmp, cond;
    ax = m_r[0];
    jmp = 0; cond = 0;
    m_br = 0;
    case (op)
      'h00, 'h01, 'h02: begin
        x = rd(a);
        res = (op == 0) ? ax + x : (op == 1) ? ax - x : ax * x;
        res = res & 255;
        m_r[0] = res; m_fl = (res == 0) ? 1 : 0;
      end
      'h0F: begin
        x = rd(a);
        if (x != 0) begin
          res = ax / x; m_r[0] = res; m_fl = (res == 0) ? 1 : 0;
        end
      end
      'h03: begin
        foreach (m_r[i]) m_r[i] = 0;
        m_fl = 0;
      end
      'h10: if (a < 4) m_r[a] = b;
      'h13: begin
        x = rd(a); y = rd(b);
        m_fl = (x == y) ? 1 : (x > y) ? 2 : 4;
      end
      'h1A: begin res = (m_r[0] & m_r[3]) | m_r[1]; if (a < 4) m_r[a] = res; end
      'h1B: begin res = m_r[3] | m_r[1]; if (a < 4) m_r[a] = res; end
      'h05: begin jmp = 1; cond = 1; end
      'h08: begin jmp = 1; cond = m_fl[1]; end
      'h09: begin jmp = 1; cond = m_fl[1] | m_fl[0]; end
      'h0A: begin jmp = 1; cond = m_fl[2]; end
      'h0B: begin jmp = 1; cond = m_fl[2] | m_fl[0]; end
      'h0C, 'h0D: begin jmp = 1; cond = m_fl[0]; end
      'h0E: begin jmp = 1; cond = !m_fl[0]; end
      default: ;
    endcase
    if (jmp && cond) begin
      m_br = 1; m_tgt = rd(a);
    end
  endtask

  task automatic compare(string tag);
    logic [31:0] er;
    er = {m_r[3][7:0], m_r[2][7:0], m_r[1][7:0], m_r[0][7:0]};
    total++;
    if (regs !== er || flags !== m_fl[2:0] || branch !== m_br || target !== m_tgt[7:0]) begin
      fails++;
      $display("FAIL %s: regs=%h flags=%b br=%b tgt=%h expected regs=%h flags=%b br=%b tgt=%h",
               tag, regs, flags, branch, target, er, m_fl[2:0], m_br, m_tgt[7:0]);
    end
  endtask

  // issue one instruction; we are at a negedge on entry and exit
  task automatic run(int op, int a, int b);
    exec = 1'b1; opcode = op[4:0]; op_a = a[7:0]; op_b = b[7:0];
    @(posedge clk);
    model_step(op, a, b);
    @(negedge clk);
    exec = 1'b0;
    compare(tag_of(op));
  endtask

  task automatic idle(int op, int a, int b);
    exec = 1'b0; opcode = op[4:0]; op_a = a[7:0]; op_b = b[7:0];
    @(posedge clk);
    m_br = 0;
    @(negedge clk);
    compare("R2");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    foreach (m_r[i]) m_r[i] = 0;
    m_fl = 0; m_tgt = 0; m_br = 0;
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);

    // R2: idle with live-looking inputs
    idle('h10, 0, 'h55);
    idle('h03, 0, 0);
    idle('h05, 1, 0);

    // R3: load all registers, out-of-range index ignored
    run('h10, 0, 'h0C);
    run('h10, 1, 'hF0);
    run('h10, 2, 'h33);
    run('h10, 3, 'h0A);
    run('h10, 4, 'h77);
    run('h10, 'hFF, 'h11);

    // R4: add wrap to zero, sub wrap, mul low byte
    run('h10, 2, 'hF4);
    run('h00, 2, 0);     // 0x0C+0xF4 = 0x100 -> 0, zf
    run('h01, 3, 0);     // 0 - 0x0A = 0xF6
    run('h02, 3, 0);     // 0xF6*0x0A low byte
    run('h00, 5, 0);     // out-of-range reads zero

    // R5: divide, divide by zero skipped
    run('h10, 2, 3);
    run('h0F, 2, 0);
    run('h10, 2, 0);
    run('h0F, 2, 0);
    run('h0F, 7, 0);

    // R6: compare eq / gt / lt, extremes
    run('h10, 0, 'hFF);
    run('h10, 3, 0);
    run('h13, 0, 3);     // gt
    run('h08, 1, 0);     // taken R8
    run('h0B, 2, 0);     // not taken
    run('h13, 3, 0);     // lt
    run('h0A, 0, 0);     // taken
    run('h09, 0, 0);     // not taken
    run('h13, 1, 1);     // eq
    run('h0C, 3, 0);
    run('h0D, 1, 0);
    run('h0E, 2, 0);     // not taken
    run('h09, 2, 0);
    run('h0B, 0, 0);
    run('h13, 0, 9);     // vs out-of-range (0)

    // R7: unconditional, then pulse ends
    run('h05, 2, 0);
    run('h10, 2, 'h5A);
    run('h05, 6, 0);

    // R9: masks
    run('h10, 0, 'h3C);
    run('h10, 1, 'h81);
    run('h10, 3, 'h0F);
    run('h1A, 2, 0);
    run('h1B, 0, 0);
    run('h1A, 9, 0);

    // R11: every unlisted opcode
    for (int op = 0; op < 32; op++) begin
      if (op inside {4, 6, 7, 'h11, 'h12, 'h14, 'h15, 'h16, 'h17, 'h18, 'h19,
                     'h1C, 'h1D, 'h1E, 'h1F})
        run(op, 1, 2);
    end

    // R10: clear
    run('h13, 1, 0);
    run('h03, 0, 0);
    run('h0E, 0, 0);

    // mixed stream
    for (int k = 0; k < 400; k++) begin
      int op, a, b;
      op = $urandom_range(0, 31);
      a  = ($urandom_range(0, 7) == 0) ? $urandom_range(4, 255) : $urandom_range(0, 3);
      b  = (op == 'h13) ? $urandom_range(0, 4) : $urandom_range(0, 255);
      if ($urandom_range(0, 9) == 0) idle(op, a, b);
      else run(op, a, b);
    end

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule